// File: doc/BRIEF.md
# RTC Time Snapshot Sequencer

This block sits between a host and a register master that talks to an external real-time clock chip. The chip stores every value as 4-bit nibbles. The host issues a single read-time or set-time command. The sequencer then owns the chip-enable line and runs a busy handshake through the chip's control register. After that it moves the whole calendar through the register master as a fixed series of nibble transfers, and it ends with either a done or a timeout pulse. The seconds, minutes, hours, day, month, year and weekday fields are all BCD. Each two-digit field occupies two neighbouring nibble addresses, and the weekday takes one.

Handshake: the block raises chip-enable, writes 24-hour mode into the control register and reads the register back. If the busy flag is set, chip-enable drops for a rest period and the handshake repeats. Too many failed attempts end in a timeout. If the read-back reports a stopped oscillator, the block clears the interrupt interval register, rewrites the control register and loads a default calendar into the chip. Because of this, a read command that meets a stopped oscillator returns the defaults.

States: `S_IDLE` waits for a command. `S_CTRL_WR` writes the mode, and `S_CTRL_RD` reads the flags. `S_RCV_INT` and `S_RCV_CTRL` perform the oscillator recovery writes. `S_XFER` runs the thirteen field transfers. `S_REST` holds chip-enable low and leaves for a retry, a finish or an abort. `S_DONE` and `S_TMO` each last one cycle and then return to `S_IDLE`.

Transitions:
- `S_IDLE` goes to `S_CTRL_WR` on a command.
- `S_CTRL_WR` goes to `S_CTRL_RD` on acknowledge.
- `S_CTRL_RD` goes to `S_RCV_INT` when the oscillator flag is set. It goes to `S_REST` when the busy flag is set. Otherwise it goes to `S_XFER`.
- `S_RCV_INT` goes to `S_RCV_CTRL`, and `S_RCV_CTRL` goes to `S_XFER`.
- `S_XFER` goes to `S_REST` after the last step.
- `S_REST` goes to `S_CTRL_WR`, `S_DONE` or `S_TMO`.

Top module: `rtc_snapshot_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `rtc_ce`, `mst_req`, `done`, `timeout` and `cmd_dropped` are 0, and `get_time` is 0.
- R2: A command raises `rtc_ce`. The first transfer writes data 0x4 to control address 0xE. The second transfer reads address 0xE. Requests occur only while `rtc_ce` is high.
- R3: In the control read-back, bit 0 is busy. When busy is set and bit 1 is clear, `rtc_ce` goes low for at least `GAP_CYCLES` cycles and the handshake starts again from R2.
- R4: The command aborts after `MAX_TRIES`+1 busy read-backs. At that point `timeout` pulses for one cycle, no field transfer takes place, and `done` does not pulse. `done` and `timeout` are never high together.
- R5: Field transfers follow the control handshake in thirteen steps. Step s (0..11) uses address s for s<6 and s+2 otherwise, and step 12 uses address 6. Step s carries nibble `time[4s+3:4s]`. The `time` field layout is seconds at [7:0], minutes at [15:8], hours at [23:16], day at [31:24], month at [39:32], year at [47:40] and weekday at [51:48], so units come before tens. A set uses writes. A request is held with a stable address until `mst_ack`.
- R6: A read performs the R5 steps as reads. In the cycle `done` is high, `get_time` shows each field as tens nibble shifted left by 4 ORed with the units nibble, with [55:52] zero. After a set, `get_time` shows the value that was written. In every other cycle `get_time` is 0.
- R7: If the control read-back has bit 1 set, the block writes 0 to address 0x7 and then 0x7 to address 0xE. It then writes the default calendar: day 01, month 01, and 00 for every other field. `done` pulses with `osc_reset` high, and `get_time` shows the defaults.
- R8: After the last field transfer, `rtc_ce` stays low for at least `GAP_CYCLES` cycles before `done` pulses.
- R9: A command that arrives while `busy` is high is ignored and pulses `cmd_dropped` one cycle later. If both commands arrive together in idle, the set runs and the read is dropped and flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_read | input | 1 | Read-time command pulse |
| cmd_set | input | 1 | Set-time command pulse |
| set_time | input | 56 | BCD calendar to write, field layout as in R5 |
| get_time | output | 56 | BCD calendar result, valid only while `done` |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | One-cycle abort pulse after too many busy replies |
| osc_reset | output | 1 | High with `done` when oscillator recovery ran |
| cmd_dropped | output | 1 | One-cycle flag for an ignored command |
| busy | output | 1 | A command is in progress |
| rtc_ce | output | 1 | Chip-enable for the clock chip |
| mst_req | output | 1 | Register transfer request, held until acknowledged |
| mst_write | output | 1 | 1 for a write transfer, 0 for a read |
| mst_addr | output | 4 | Nibble register address |
| mst_wdata | output | 4 | Nibble to write |
| mst_ack | input | 1 | Transfer finished; read data valid |
| mst_rdata | input | 4 | Nibble read from the chip |

## Verification
The bench builds the block with `MAX_TRIES` = 3 and `GAP_CYCLES` = 4. With these values every busy count from zero up to the abort threshold can be swept in a few hundred cycles, and every rest interval can be measured against a small bound. A model register master with a nibble register file checks twelve arithmetic calendar patterns written and then read back. The model also injects busy replies and a stopped oscillator on demand, so the retry, abort and recovery paths are exercised in full.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CTRL_WR,
        S_CTRL_RD,
        S_RCV_INT,
        S_RCV_CTRL,
        S_XFER,
        S_REST,
        S_DONE,
        S_TMO
    } seq_state_t;

    typedef enum logic [1:0] {
        AFTER_RETRY,
        AFTER_DONE,
        AFTER_TMO
    } rest_exit_t;

    localparam logic [3:0] ADDR_CTRL     = 4'hE;
    localparam logic [3:0] ADDR_INTV     = 4'h7;
    localparam logic [3:0] ADDR_WDAY     = 4'h6;
    localparam logic [3:0] CTRL_24H      = 4'h4;
    localparam logic [3:0] CTRL_RECOVER  = 4'h7;
    localparam int         LAST_STEP     = 12;
    localparam logic [55:0] DEFAULT_TIME = {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    function automatic logic [3:0] step_addr(input logic [3:0] step);
        if (step == 4'(LAST_STEP))
            return ADDR_WDAY;
        else if (step < 4'd6)
            return step;
        else
            return step + 4'd2;
    endfunction

endpackage

// File: rtl/rtc_snapshot_seq.sv
module rtc_snapshot_seq
    import rtc_seq_pkg::*;
#(
    parameter int MAX_TRIES  = 100,
    parameter int GAP_CYCLES = 175
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_read,
    input  logic        cmd_set,
    input  logic [55:0] set_time,
    output logic [55:0] get_time,
    output logic        done,
    output logic        timeout,
    output logic        osc_reset,
    output logic        cmd_dropped,
    output logic        busy,
    output logic        rtc_ce,
    output logic        mst_req,
    output logic        mst_write,
    output logic [3:0]  mst_addr,
    output logic [3:0]  mst_wdata,
    input  logic        mst_ack,
    input  logic [3:0]  mst_rdata
);

    localparam int TW = (MAX_TRIES < 1) ? 1 : $clog2(MAX_TRIES + 1);
    localparam int GW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES + 1);

    seq_state_t  state_q, state_d;
    rest_exit_t  exit_q;
    logic        is_set_q;
    logic        osc_q;
    logic [TW-1:0] tries_q;
    logic [GW-1:0] gap_q;
    logic [3:0]  step_q;
    logic [55:0] time_q;
    logic        dropped_q;

    logic cmd_any;
    logic rb_osc, rb_busy, tries_spent, gap_end, last_step;

    assign cmd_any     = cmd_read | cmd_set;
    assign rb_osc      = mst_rdata[1];
    assign rb_busy     = mst_rdata[0];
    assign tries_spent = (tries_q == TW'(MAX_TRIES));
    assign gap_end     = (gap_q == GW'(GAP_CYCLES - 1));
    assign last_step   = (step_q == 4'(LAST_STEP));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (cmd_any) state_d = S_CTRL_WR;
            S_CTRL_WR:  if (mst_ack) state_d = S_CTRL_RD;
            S_CTRL_RD:  if (mst_ack) begin
                            if (rb_osc)       state_d = S_RCV_INT;
                            else if (rb_busy) state_d = S_REST;
                            else              state_d = S_XFER;
                        end
            S_RCV_INT:  if (mst_ack) state_d = S_RCV_CTRL;
            S_RCV_CTRL: if (mst_ack) state_d = S_XFER;
            S_XFER:     if (mst_ack && last_step) state_d = S_REST;
            S_REST:     if (gap_end) begin
                            unique case (exit_q)
                                AFTER_RETRY: state_d = S_CTRL_WR;
                                AFTER_DONE:  state_d = S_DONE;
                                default:     state_d = S_TMO;
                            endcase
                        end
            S_DONE:     state_d = S_IDLE;
            S_TMO:      state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            exit_q    <= AFTER_RETRY;
            is_set_q  <= 1'b0;
            osc_q     <= 1'b0;
            tries_q   <= '0;
            gap_q     <= '0;
            step_q    <= '0;
            time_q    <= '0;
            dropped_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            dropped_q <= (state_q != S_IDLE) ? cmd_any : (cmd_read & cmd_set);
            unique case (state_q)
                S_IDLE: if (cmd_any) begin
                    is_set_q <= cmd_set;
                    osc_q    <= 1'b0;
                    tries_q  <= '0;
                    step_q   <= '0;
                    time_q   <= cmd_set ? {4'h0, set_time[51:0]} : 56'h0;
                end
                S_CTRL_RD: if (mst_ack) begin
                    gap_q <= '0;
                    if (!rb_osc && rb_busy) begin
                        if (tries_spent) begin
                            exit_q <= AFTER_TMO;
                        end else begin
                            exit_q  <= AFTER_RETRY;
                            tries_q <= tries_q + 1'b1;
                        end
                    end
                end
                S_RCV_CTRL: if (mst_ack) begin
                    is_set_q <= 1'b1;
                    osc_q    <= 1'b1;
                    time_q   <= DEFAULT_TIME;
                end
                S_XFER: if (mst_ack) begin
                    if (!is_set_q) time_q[{step_q, 2'b00} +: 4] <= mst_rdata;
                    if (last_step) begin
                        exit_q <= AFTER_DONE;
                        gap_q  <= '0;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                S_REST: gap_q <= gap_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rtc_ce      = 1'b0;
        mst_req     = 1'b0;
        mst_write   = 1'b0;
        mst_addr    = 4'h0;
        mst_wdata   = 4'h0;
        done        = (state_q == S_DONE);
        timeout     = (state_q == S_TMO);
        osc_reset   = (state_q == S_DONE) && osc_q;
        get_time    = (state_q == S_DONE) ? time_q : 56'h0;
        busy        = (state_q != S_IDLE);
        cmd_dropped = dropped_q;
        unique case (state_q)
            S_CTRL_WR:  begin rtc_ce = 1'b1; mst_req = 1'b1; mst_write = 1'b1;
                              mst_addr = ADDR_CTRL; mst_wdata = CTRL_24H; end
            S_CTRL_RD:  begin rtc_ce = 1'b1; mst_req = 1'b1; mst_addr = ADDR_CTRL; end
            S_RCV_INT:  begin rtc_ce = 1'b1; mst_req = 1'b1; mst_write = 1'b1;
                              mst_addr = ADDR_INTV; mst_wdata = 4'h0; end
            S_RCV_CTRL: begin rtc_ce = 1'b1; mst_req = 1'b1; mst_write = 1'b1;
                              mst_addr = ADDR_CTRL; mst_wdata = CTRL_RECOVER; end
            S_XFER:     begin rtc_ce = 1'b1; mst_req = 1'b1; mst_write = is_set_q;
                              mst_addr = step_addr(step_q);
                              mst_wdata = is_set_q ? time_q[{step_q, 2'b00} +: 4] : 4'h0; end
            default: ;
        endcase
    end

endmodule

// File: rtl/rtc_snapshot_seq_chk.sv
module rtc_snapshot_seq_chk #(
    parameter int GAP_CYCLES = 175
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_read,
    input logic        cmd_set,
    input logic        busy,
    input logic        cmd_dropped,
    input logic        done,
    input logic        timeout,
    input logic [55:0] get_time,
    input logic        rtc_ce,
    input logic        mst_req,
    input logic        mst_ack,
    input logic        mst_write,
    input logic [3:0]  mst_addr
);

    int low_run;

    always_ff @(posedge clk) begin
        if (!rst_n)            low_run <= GAP_CYCLES;
        else if (rtc_ce)       low_run <= 0;
        else if (low_run < GAP_CYCLES) low_run <= low_run + 1;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rtc_ce && !mst_req));

    p_req_inside_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mst_req |-> rtc_ce);

    p_ce_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rtc_ce) |-> (low_run >= GAP_CYCLES));

    p_done_tmo_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));

    p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && !mst_ack) |=> (mst_req && $stable(mst_addr) && $stable(mst_write)));

    p_outputs_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (get_time == 56'h0));

    p_done_after_rest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (low_run >= GAP_CYCLES));

    p_drop_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_dropped |-> $past(busy || (cmd_read && cmd_set)));

endmodule

bind rtc_snapshot_seq rtc_snapshot_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_read(cmd_read), .cmd_set(cmd_set),
    .busy(busy), .cmd_dropped(cmd_dropped), .done(done), .timeout(timeout),
    .get_time(get_time), .rtc_ce(rtc_ce), .mst_req(mst_req), .mst_ack(mst_ack),
    .mst_write(mst_write), .mst_addr(mst_addr)
);

// File: tb/rtc_snapshot_seq_bench.sv
module rtc_snapshot_seq_bench;

    localparam int MAXT = 3;
    localparam int GAP  = 4;
    localparam int LOGN = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_read = 1'b0, cmd_set = 1'b0;
    logic [55:0] set_time = '0;
    logic [55:0] get_time;
    logic        done, timeout, osc_reset, cmd_dropped, busy, rtc_ce;
    logic        mst_req, mst_write, mst_ack;
    logic [3:0]  mst_addr, mst_wdata, mst_rdata;

    always #2 clk = ~clk;

    rtc_snapshot_seq #(.MAX_TRIES(MAXT), .GAP_CYCLES(GAP)) u_rtc_snapshot_seq (
        .clk(clk), .rst_n(rst_n), .cmd_read(cmd_read), .cmd_set(cmd_set),
        .set_time(set_time), .get_time(get_time), .done(done), .timeout(timeout),
        .osc_reset(osc_reset), .cmd_dropped(cmd_dropped), .busy(busy),
        .rtc_ce(rtc_ce), .mst_req(mst_req), .mst_write(mst_write),
        .mst_addr(mst_addr), .mst_wdata(mst_wdata), .mst_ack(mst_ack),
        .mst_rdata(mst_rdata)
    );

    // model register master and chip
    logic [3:0] rf [16];
    logic [3:0] lg_addr [LOGN];
    logic       lg_w    [LOGN];
    logic [3:0] lg_d    [LOGN];
    int lg_n = 0, rd_cnt = 0, rec_cnt = 0;
    int rd_base = 0, busy_cfg = 0, rec_base = 0;
    logic osc_cfg = 1'b0;
    logic pend = 1'b0;
    int   lat = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mst_ack <= 1'b0; mst_rdata <= 4'h0; pend <= 1'b0;
            for (int i = 0; i < 16; i++) rf[i] <= 4'h0;
        end else begin
            mst_ack <= 1'b0;
            if (pend) begin
                if (lat == 0) begin
                    mst_ack <= 1'b1;
                    pend    <= 1'b0;
                    lg_addr[lg_n % LOGN] <= mst_addr;
                    lg_w[lg_n % LOGN]    <= mst_write;
                    lg_d[lg_n % LOGN]    <= mst_wdata;
                    lg_n <= lg_n + 1;
                    if (mst_write) begin
                        if (mst_addr == 4'hE && mst_wdata == 4'h7) rec_cnt <= rec_cnt + 1;
                        else if (mst_addr != 4'hE) rf[mst_addr] <= mst_wdata;
                    end else if (mst_addr == 4'hE) begin
                        mst_rdata <= {2'b00, osc_cfg && (rec_cnt == rec_base),
                                      (rd_cnt - rd_base) < busy_cfg};
                        rd_cnt <= rd_cnt + 1;
                    end else begin
                        mst_rdata <= rf[mst_addr];
                    end
                end else lat <= lat - 1;
            end else if (mst_req && !mst_ack) begin
                pend <= 1'b1;
                lat  <= 1;
            end
        end
    end

    // gap monitor: CE rises after a short low run
    int low_run = 100, short_gaps = 0;
    logic ce_prev = 1'b0;
    always @(negedge clk) begin
        if (rtc_ce && !ce_prev && low_run < GAP) short_gaps <= short_gaps + 1;
        if (rtc_ce) low_run <= 0; else low_run <= low_run + 1;
        ce_prev <= rtc_ce;
    end

    int checks = 0, fails = 0, cycles = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            $display("FAIL watchdog: act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [3:0] exp_addr(input int s);
        if (s == 12) return 4'h6;
        return (s < 6) ? 4'(s) : 4'(s + 2);
    endfunction

    // run a command; returns outcome and the time seen while done
    task automatic run_cmd(input logic do_set, input logic [55:0] tv,
                           output logic [55:0] got, output logic saw_done,
                           output logic saw_tmo, output logic saw_osc,
                           output int done_low, output int leak);
        int guard = 0;
        int lr = 0;
        saw_done = 0; saw_tmo = 0; saw_osc = 0; got = '0; done_low = 0; leak = 0;
        @(negedge clk);
        set_time = tv; cmd_set = do_set; cmd_read = !do_set;
        @(negedge clk);
        cmd_set = 0; cmd_read = 0;
        while (!saw_done && !saw_tmo && guard < 2000) begin
            if (rtc_ce) lr = 0; else lr++;
            if (!done && get_time != 0) leak++;
            if (done) begin saw_done = 1; got = get_time; saw_osc = osc_reset; done_low = lr; end
            if (timeout) saw_tmo = 1;
            if (!saw_done && !saw_tmo) begin @(negedge clk); guard++; end
        end
    endtask

    // compare the 13 field steps starting at log index b
    function automatic int field_bad(input int b, input logic w, input logic [55:0] tv);
        int bad = 0;
        for (int s = 0; s < 13; s++) begin
            int k = (b + s) % LOGN;
            if (lg_addr[k] != exp_addr(s) || lg_w[k] != w) bad++;
            if (w && lg_d[k] != tv[s*4 +: 4]) bad++;
        end
        return bad;
    endfunction

    function automatic int hs_bad(input int b, input int pairs);
        int bad = 0;
        for (int p = 0; p < pairs; p++) begin
            int k = (b + 2*p) % LOGN;
            if (lg_addr[k] != 4'hE || !lg_w[k] || lg_d[k] != 4'h4) bad++;
            if (lg_addr[(k+1) % LOGN] != 4'hE || lg_w[(k+1) % LOGN]) bad++;
        end
        return bad;
    endfunction

    initial begin
        logic [55:0] got;
        logic sd, st, so;
        int dl, lk, base;
        logic [55:0] tv;

        repeat (3) @(negedge clk);
        chk(!busy && !rtc_ce && !mst_req && !done && !timeout && !cmd_dropped && get_time == 0,
            "R1 reset state", {busy, rtc_ce, mst_req, done, timeout, cmd_dropped}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // write then read twelve arithmetic calendars
        for (int p = 0; p < 12; p++) begin
            tv = {4'h0, 4'(p % 7), bcd((p*17) % 100), bcd(1 + p % 12), bcd(1 + (p*3) % 31),
                  bcd((p*5) % 24), bcd((p*13 + 5) % 60), bcd((p*7) % 60)};
            base = lg_n;
            run_cmd(1'b1, tv, got, sd, st, so, dl, lk);
            chk(sd && !st, "R5 set completes", {sd, st}, 2'b10);
            chk(hs_bad(base, 1) == 0, "R2 set handshake ops", hs_bad(base, 1), 0);
            chk(field_bad(base + 2, 1'b1, tv) == 0, "R5 set field order/data", field_bad(base + 2, 1'b1, tv), 0);
            chk(lg_n - base == 15, "R5 set op count", lg_n - base, 15);
            chk(got == tv, "R6 set result shown at done", got, tv);
            chk(dl >= GAP + 1, "R8 rest before done", dl, GAP + 1);
            base = lg_n;
            run_cmd(1'b0, 56'h0, got, sd, st, so, dl, lk);
            chk(sd && got == tv, "R6 readback value", got, tv);
            chk(field_bad(base + 2, 1'b0, tv) == 0 && hs_bad(base, 1) == 0,
                "R6 read op order", field_bad(base + 2, 1'b0, tv), 0);
            chk(lk == 0, "R6 outputs zero outside done", lk, 0);
        end

        // busy sweep up to the abort threshold
        for (int b = 0; b <= MAXT + 1; b++) begin
            rd_base = rd_cnt; busy_cfg = b;
            base = lg_n;
            run_cmd(1'b0, 56'h0, got, sd, st, so, dl, lk);
            if (b <= MAXT) begin
                chk(sd && !st, "R3 completes after busy retries", {sd, st}, 2'b10);
                chk(hs_bad(base, b + 1) == 0, "R3 handshake repeated", hs_bad(base, b + 1), 0);
                chk(lg_n - base == 2*(b+1) + 13, "R3 op count", lg_n - base, 2*(b+1) + 13);
            end else begin
                chk(st && !sd, "R4 timeout after too many busy", {st, sd}, 2'b10);
                chk(lg_n - base == 2*(MAXT+1), "R4 no field transfers", lg_n - base, 2*(MAXT+1));
                @(negedge clk);
                chk(!rtc_ce && !timeout && !busy, "R4 idle after timeout", {rtc_ce, timeout, busy}, 0);
            end
        end
        busy_cfg = 0;
        chk(short_gaps == 0, "R3 chip-enable rest length", short_gaps, 0);

        // oscillator stop recovery on a read command
        rec_base = rec_cnt; osc_cfg = 1'b1;
        base = lg_n;
        run_cmd(1'b0, 56'h0, got, sd, st, so, dl, lk);
        tv = {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
        chk(sd && so, "R7 done with osc_reset", {sd, so}, 2'b11);
        chk(got == tv, "R7 default calendar returned", got, tv);
        chk(lg_addr[(base+2)%LOGN] == 4'h7 && lg_w[(base+2)%LOGN] && lg_d[(base+2)%LOGN] == 4'h0 &&
            lg_addr[(base+3)%LOGN] == 4'hE && lg_w[(base+3)%LOGN] && lg_d[(base+3)%LOGN] == 4'h7,
            "R7 recovery writes", {lg_addr[(base+2)%LOGN], lg_addr[(base+3)%LOGN]}, 8'h7E);
        chk(field_bad(base + 4, 1'b1, tv) == 0, "R7 default fields written", field_bad(base + 4, 1'b1, tv), 0);
        base = lg_n;
        run_cmd(1'b0, 56'h0, got, sd, st, so, dl, lk);
        chk(sd && !so && got == tv, "R7 defaults read back, flag clear", got, tv);
        osc_cfg = 1'b0;

        // command while busy is dropped
        tv = {4'h0, 4'h3, 8'h24, 8'h07, 8'h15, 8'h09, 8'h41, 8'h33};
        base = lg_n;
        @(negedge clk);
        set_time = tv; cmd_set = 1;
        @(negedge clk);
        cmd_set = 0;
        repeat (3) @(negedge clk);
        cmd_read = 1;
        @(negedge clk);
        cmd_read = 0;
        chk(cmd_dropped, "R9 drop flag while busy", cmd_dropped, 1);
        begin
            int g = 0;
            while (!done && g < 2000) begin @(negedge clk); g++; end
        end
        repeat (30) @(negedge clk);
        chk(lg_n - base == 15 && !busy, "R9 dropped command has no effect", lg_n - base, 15);

        // simultaneous commands in idle: set wins
        tv = {4'h0, 4'h5, 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h58};
        base = lg_n;
        @(negedge clk);
        set_time = tv; cmd_set = 1; cmd_read = 1;
        @(negedge clk);
        cmd_set = 0; cmd_read = 0;
        chk(cmd_dropped, "R9 simultaneous read flagged", cmd_dropped, 1);
        begin
            int g = 0;
            while (!done && g < 2000) begin @(negedge clk); g++; end
        end
        chk(field_bad(base + 2, 1'b1, tv) == 0, "R9 simultaneous runs set", field_bad(base + 2, 1'b1, tv), 0);

        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule